// File: doc/BRIEF.md
# Selectable Output Clock Generator

This block drives a clock pin for an external microcontroller. Seven of its eight settings divide a fast reference clock. One of these is the non-integer ratio 7.5, made by alternating output periods of 7 and 8 reference cycles. The eighth setting passes through a separate low-frequency clock input. A control byte, written through a simple register port, holds the frequency select, a low-frequency-enable flag and a two-bit tail field. The tail field is only stored.

When the low-frequency-enable flag is set and the sleep input is high, the low-frequency clock goes to the pin whatever the select field holds. Every change of source goes through a glitch-free handover. Each side drops its enable only while its own clock is low. The other side picks up only after it has seen that release through a synchronizer.

Top module: `clkout_gen`

## Requirements
- R1: After reset the control byte reads 06h, and the output runs at the reference divided by 30 with a 50% duty cycle.
- R2: The control byte has select in bits 2:0, low-frequency enable in bit 3 and tail in bits 5:4. A write appears on `rd_data_o` one cycle later. Bits 7:6 always read 0.
- R3: Select values 000, 001, 010, 100, 101 and 110 give output periods of 1, 2, 3, 10, 15 and 30 reference cycles.
- R4: The high time is half the period for the even ratios and ratio 1. For ratios 3 and 15 it is 1 and 7 reference cycles, which is within one cycle of half.
- R5: Select 011 gives output periods that alternate between 7 and 8 reference cycles, with a high time of 4 cycles. Two consecutive periods add up to 15 cycles.
- R6: Select 111 drives the low-frequency clock input to the output.
- R7: With bit 3 set and sleep high, the output is the low-frequency clock for any select value.
- R8: With bit 3 clear, or with sleep low, the output follows the select field.
- R9: The tail bits do not change the output frequency.
- R10: The output never carries a pulse shorter than half a reference period, and the two source enables are never on together.
- R11: A change of select restarts the divider. For a divided setting, the first rising edge comes two reference edges after the edge that wrote the new select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock; also clocks the register port |
| lfclk_i | input | 1 | Low-frequency clock source |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Control byte write strobe |
| wr_data_i | input | 8 | Control byte write value |
| rd_data_o | output | 8 | Control byte read value |
| sleep_i | input | 1 | Sleep state indication (asynchronous) |
| clk_o | output | 1 | Generated output clock |

## Verification
The bench steps through every select value and measures the period and high time of each at the pin. This separates the integer ratios from one another and from the alternating 7/8 pattern, which only two consecutive periods reveal. Sleep and the enable flag are tried in all four combinations with two different select values, which separates the override from a plain select of 111. Tail-only writes compared against the default, and the delay to the first edge after a select change, show that the tail is ignored and that the divider restarts. A pulse-width monitor runs throughout and catches any glitch at a handover.

// File: rtl/clkout_pkg.sv
`timescale 1ns/1ps
package clkout_pkg;
  localparam int unsigned SEL_W    = 3;
  localparam int unsigned CTRL_W   = 8;
  localparam int unsigned STORE_W  = 6;
  localparam int unsigned LFEN_BIT = 3;
  localparam int unsigned MAX_DIV  = 30;
  localparam int unsigned CNT_W    = $clog2(MAX_DIV + 1);
  localparam int unsigned FRAC_LO  = 7;
  localparam logic [CTRL_W-1:0] CTRL_RST = 8'h06;
  localparam logic [SEL_W-1:0]  SEL_LF   = 3'd7;

  typedef enum logic [1:0] {SRC_BYP, SRC_DIV, SRC_FRAC, SRC_LF} src_e;

  typedef struct packed {
    src_e             src;
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] high;
  } div_cfg_t;

  function automatic int unsigned sel_ratio(input logic [SEL_W-1:0] sel);
    unique case (sel)
      3'd0:    return 1;
      3'd1:    return 2;
      3'd2:    return 3;
      3'd3:    return FRAC_LO;
      3'd4:    return 10;
      3'd5:    return 15;
      3'd6:    return 30;
      default: return 1;
    endcase
  endfunction

  function automatic div_cfg_t decode_sel(input logic [SEL_W-1:0] sel);
    div_cfg_t    c;
    int unsigned r;
    r        = sel_ratio(sel);
    c.period = CNT_W'(r);
    c.high   = CNT_W'(r / 2);
    unique case (sel)
      3'd0:    c.src = SRC_BYP;
      3'd3:    begin c.src = SRC_FRAC; c.high = CNT_W'(FRAC_LO / 2 + 1); end
      SEL_LF:  c.src = SRC_LF;
      default: c.src = SRC_DIV;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/clkout_sync.sv
`timescale 1ns/1ps
module clkout_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] s_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) s_q <= {STAGES{RST_VAL}};
    else         s_q <= {s_q[STAGES-2:0], d_i};
  end

  assign q_o = s_q[STAGES-1];
endmodule

// File: rtl/clkout_ctrl_reg.sv
`timescale 1ns/1ps
module clkout_ctrl_reg
  import clkout_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  output logic [CTRL_W-1:0] q_o
);
  localparam int unsigned PAD_W = CTRL_W - STORE_W;

  logic [STORE_W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q <= CTRL_RST[STORE_W-1:0];
    else if (wr_en_i) q <= wr_data_i[STORE_W-1:0];
  end

  assign q_o = {{PAD_W{1'b0}}, q};
endmodule

// File: rtl/clkout_ref_div.sv
`timescale 1ns/1ps
module clkout_ref_div
  import clkout_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic             ref_clk_o,
  output logic             div_o,
  output logic             byp_o
);
  div_cfg_t         cfg;
  logic [SEL_W-1:0] sel_prev;
  logic             restart;
  logic [CNT_W-1:0] cnt, cnt_nxt, period;
  logic             frac_ph, wrap, div_q, byp_q;

  assign cfg     = decode_sel(sel_i);
  assign restart = (sel_i != sel_prev);

  always_comb begin
    period  = cfg.period + CNT_W'(cfg.src == SRC_FRAC && frac_ph);
    wrap    = (cnt >= period - CNT_W'(1));
    cnt_nxt = wrap ? '0 : cnt + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_prev <= CTRL_RST[SEL_W-1:0];
      cnt      <= '1;
      frac_ph  <= 1'b0;
      div_q    <= 1'b0;
    end else begin
      sel_prev <= sel_i;
      if (restart || cfg.src == SRC_BYP || cfg.src == SRC_LF) begin
        // all-ones wraps on the next edge, so the first high phase starts there
        cnt     <= '1;
        frac_ph <= 1'b0;
        div_q   <= 1'b0;
      end else begin
        cnt   <= cnt_nxt;
        div_q <= (cnt_nxt < cfg.high);
        if (wrap && cfg.src == SRC_FRAC) frac_ph <= ~frac_ph;
      end
    end
  end

  // bypass gate opens only while the reference is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) byp_q <= 1'b0;
    else         byp_q <= (cfg.src == SRC_BYP) && !restart;
  end

  assign ref_clk_o = (clk_i & byp_q) | div_q;
  assign div_o     = div_q;
  assign byp_o     = byp_q;
endmodule

// File: rtl/clkout_gf_mux.sv
`timescale 1ns/1ps
module clkout_gf_mux #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_a_i,
  input  logic src_a_i,
  input  logic clk_b_i,
  input  logic rst_ni,
  input  logic sel_b_i,
  output logic clk_o,
  output logic en_a_o,
  output logic en_b_o
);
  logic en_a_q, en_b_q;
  logic b_off_s, b_req_s, sel_b_s, a_off_s;

  clkout_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync_b_off (
    .clk_i(clk_a_i), .rst_ni(rst_ni), .d_i(~en_b_q), .q_o(b_off_s));
  clkout_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync_b_req (
    .clk_i(clk_a_i), .rst_ni(rst_ni), .d_i(sel_b_s), .q_o(b_req_s));
  clkout_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync_sel_b (
    .clk_i(clk_b_i), .rst_ni(rst_ni), .d_i(sel_b_i), .q_o(sel_b_s));
  clkout_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync_a_off (
    .clk_i(clk_b_i), .rst_ni(rst_ni), .d_i(~en_a_q), .q_o(a_off_s));

  always_ff @(negedge clk_a_i or negedge rst_ni) begin
    if (!rst_ni) en_a_q <= 1'b1;
    else         en_a_q <= ~sel_b_i & b_off_s & ~b_req_s;
  end

  always_ff @(negedge clk_b_i or negedge rst_ni) begin
    if (!rst_ni) en_b_q <= 1'b0;
    else         en_b_q <= sel_b_s & a_off_s;
  end

  assign clk_o  = (src_a_i & en_a_q) | (clk_b_i & en_b_q);
  assign en_a_o = en_a_q;
  assign en_b_o = en_b_q;
endmodule

// File: rtl/clkout_gen.sv
`timescale 1ns/1ps
module clkout_gen
  import clkout_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              lfclk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  output logic [CTRL_W-1:0] rd_data_o,
  input  logic              sleep_i,
  output logic              clk_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [SEL_W-1:0]  sel;
  logic              lf_en, sleep_s, sel_lf;
  logic              ref_clk, div_q, byp_en, en_ref, en_lf;

  clkout_ctrl_reg i_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .q_o(ctrl_q));

  assign rd_data_o = ctrl_q;
  assign sel       = ctrl_q[SEL_W-1:0];
  assign lf_en     = ctrl_q[LFEN_BIT];

  clkout_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync_sleep (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sleep_i), .q_o(sleep_s));

  assign sel_lf = (sel == SEL_LF) | (lf_en & sleep_s);

  clkout_ref_div i_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel),
    .ref_clk_o(ref_clk), .div_o(div_q), .byp_o(byp_en));

  clkout_gf_mux #(.SYNC_STAGES(SYNC_STAGES)) i_mux (
    .clk_a_i(clk_i), .src_a_i(ref_clk), .clk_b_i(lfclk_i), .rst_ni(rst_ni),
    .sel_b_i(sel_lf), .clk_o(clk_o), .en_a_o(en_ref), .en_b_o(en_lf));
endmodule

// File: rtl/clkout_gen_chk.sv
`timescale 1ns/1ps
module clkout_gen_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic [7:0] wr_data_i,
  input logic [7:0] rd_data_o,
  input logic [2:0] sel_i,
  input logic       div_i,
  input logic       byp_i,
  input logic       en_ref_i,
  input logic       en_lf_i
);
  AST_UPPER_BITS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[7:6] == 2'b00);  // R2
  AST_WRITE_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rd_data_o == {2'b00, $past(wr_data_i[5:0])});  // R2
  AST_SINGLE_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_ref_i && en_lf_i));  // R10
  AST_BYP_DIV_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(byp_i && div_i));  // R10
  AST_LF_DIV_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'd7 && $stable(sel_i)) |=> !div_i);  // R6
  AST_SEL_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sel_i) |=> !div_i);  // R11
endmodule

bind clkout_gen clkout_gen_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
  .rd_data_o(rd_data_o), .sel_i(sel), .div_i(div_q), .byp_i(byp_en),
  .en_ref_i(en_ref), .en_lf_i(en_lf));

// File: tb/test_clkout_gen.sv
`timescale 1ns/1ps
module test_clkout_gen;
  logic       clk = 1'b0, lfclk = 1'b0, rst_n = 1'b0;
  logic       wr_en = 1'b0, sleep = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       clk_out;
  int         tests = 0, fails = 0, glitches = 0;
  realtime    last_edge = 0.0;

  localparam int REF_NS = 8;
  localparam int LF_NS  = 100;

  always #4  clk   = ~clk;
  always #50 lfclk = ~lfclk;

  clkout_gen i_clkout_gen (
    .clk_i(clk), .lfclk_i(lfclk), .rst_ni(rst_n), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .rd_data_o(rd_data), .sleep_i(sleep), .clk_o(clk_out));

  // pulse-width monitor, R10
  always @(clk_out) begin
    if (rst_n) begin
      if ($realtime - last_edge < 3.9) glitches++;
      last_edge = $realtime;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (200) @(posedge clk);
    #2;
  endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = d;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
  endtask

  task automatic measure(output int per, output int hi);
    realtime r0, f0, r1;
    @(posedge clk_out);
    @(posedge clk_out); r0 = $realtime;
    @(negedge clk_out); f0 = $realtime;
    @(posedge clk_out); r1 = $realtime;
    per = $rtoi(r1 - r0 + 0.5);
    hi  = $rtoi(f0 - r0 + 0.5);
  endtask

  task automatic t_reset();
    int per, hi;
    chk(rd_data == 8'h06, "R1 reset value", rd_data, 8'h06);
    measure(per, hi);
    chk(per == 30 * REF_NS, "R1 default period", per, 30 * REF_NS);
    chk(hi == 15 * REF_NS, "R1 default high", hi, 15 * REF_NS);
  endtask

  task automatic t_regs();
    do_write(8'h3A);
    chk(rd_data == 8'h3A, "R2 readback", rd_data, 8'h3A);
    do_write(8'hFF);
    chk(rd_data == 8'h3F, "R2 upper bits zero", rd_data, 8'h3F);
    do_write(8'h06);
    chk(rd_data == 8'h06, "R2 restore", rd_data, 8'h06);
  endtask

  task automatic t_ratios();
    int ratio[7] = '{1, 2, 3, 0, 10, 15, 30};
    int hiref[7] = '{4, 8, 8, 0, 40, 56, 120};
    int per, hi;
    for (int s = 0; s < 7; s++) begin
      if (s == 3) continue;
      do_write(8'(s));
      settle();
      measure(per, hi);
      chk(per == ratio[s] * REF_NS, "R3 period", per, ratio[s] * REF_NS);
      chk(hi == hiref[s], "R4 high time", hi, hiref[s]);
    end
  endtask

  task automatic t_frac();
    realtime a, b, c;
    int p1, p2;
    do_write(8'h03);
    settle();
    @(posedge clk_out); a = $realtime;
    @(posedge clk_out); b = $realtime;
    @(posedge clk_out); c = $realtime;
    p1 = $rtoi(b - a + 0.5);
    p2 = $rtoi(c - b + 0.5);
    chk(p1 + p2 == 15 * REF_NS, "R5 pair sum", p1 + p2, 15 * REF_NS);
    chk((p1 == 56 && p2 == 64) || (p1 == 64 && p2 == 56), "R5 alternation", p1, 56);
  endtask

  task automatic t_lf_select();
    int per, hi;
    do_write(8'h07);
    settle();
    measure(per, hi);
    chk(per == LF_NS, "R6 lf period", per, LF_NS);
    chk(hi == LF_NS / 2, "R6 lf high", hi, LF_NS / 2);
  endtask

  task automatic t_sleep();
    int per, hi;
    do_write(8'h08);
    sleep = 1'b1;
    settle();
    measure(per, hi);
    chk(per == LF_NS, "R7 override sel 000", per, LF_NS);
    do_write(8'h0C);
    settle();
    measure(per, hi);
    chk(per == LF_NS, "R7 override sel 100", per, LF_NS);
    sleep = 1'b0;
    settle();
    measure(per, hi);
    chk(per == 10 * REF_NS, "R8 wake follows sel", per, 10 * REF_NS);
    do_write(8'h04);
    sleep = 1'b1;
    settle();
    measure(per, hi);
    chk(per == 10 * REF_NS, "R8 sleep without enable", per, 10 * REF_NS);
    sleep = 1'b0;
    do_write(8'h00);
    settle();
    measure(per, hi);
    chk(per == REF_NS, "R8 bypass after sleep", per, REF_NS);
  endtask

  task automatic t_tail();
    int per, hi;
    do_write(8'h36);
    settle();
    chk(rd_data == 8'h36, "R9 tail stored", rd_data, 8'h36);
    measure(per, hi);
    chk(per == 30 * REF_NS, "R9 tail no effect", per, 30 * REF_NS);
    do_write(8'h16);
    settle();
    measure(per, hi);
    chk(per == 30 * REF_NS, "R9 other tail no effect", per, 30 * REF_NS);
  endtask

  task automatic t_restart();
    realtime t0;
    int d;
    do_write(8'h06);
    settle();
    do_write(8'h04);
    t0 = $realtime;
    @(posedge clk_out);
    d = $rtoi($realtime - t0 + 0.5);
    chk(d == 2 * REF_NS - 1, "R11 first edge after change", d, 2 * REF_NS - 1);
  endtask

  initial begin
    #1000000;
    fails++;
    tests++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_regs();
    t_ratios();
    t_frac();
    t_lf_select();
    t_sleep();
    t_tail();
    t_restart();
    settle();
    chk(glitches == 0, "R10 no short pulse", glitches, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule